// File: doc/BRIEF.md
# Serial Clock-Synthesizer Register Loader

This block writes one register of an external programmable clock synthesizer over two bit-banged wires: a program clock and a program data line. The host supplies a 3-bit register address and four divider fields: the feedback value Q, the reference value P, a 3-bit post-divider select M and a 4-bit index. The block packs them into a 21-bit word and appends the address. It then plays out a complete frame: an unlock preamble, a start pattern, 24 payload bits and a stop pattern.

Each payload bit is sent as a short sequence of (clock, data) pin states. A zero and a one use different step sequences. Every pin state is held for a parameterised number of system clocks, so the synthesizer's setup time is met whatever the system clock rate. The host raises `start_i` for one cycle while the block is idle, watches `busy_o`, and gets a single-cycle `done_o` when the frame is finished. The inputs are captured when a request is accepted, so they may change while the frame is running.

Top module: `synth_reg_loader`

## Requirements
- R1: While reset is held and right after it, the pins rest at program clock 1 and program data 0, with `busy_o` and `done_o` both 0.
- R2: A start request is accepted only in a cycle where `busy_o` is low. A request raised while a frame runs has no effect on the pins, on `busy_o` or on the number of `done_o` pulses.
- R3: The frame begins with an unlock preamble of (clock, data) steps: (0,1), then five full pulses (1,1),(0,1), with data held high throughout.
- R4: After the preamble comes the start pattern: (0,0), (1,0), (0,0), (1,0).
- R5: A payload bit of value 0 is sent as the five steps (1,0), (1,1), (0,1), (0,0), (1,0).
- R6: A payload bit of value 1 is sent as the four steps (1,0), (0,0), (0,1), (1,1).
- R7: The frame ends with the stop pattern (1,1), (0,1), (1,1), (1,0).
- R8: The payload is 24 bits. First come the 21 word bits from bit 0 to bit 20, then the 3 address bits from bit 0 to bit 2.
- R9: The word holds Q minus 2 in bits 6..0, M in bits 9..7, P minus 3 in bits 16..10 and the index in bits 20..17. P and Q are 8-bit unsigned inputs, and only the low 7 bits of each difference are kept.
- R10: Every pin state of a frame lasts exactly `HOLD_CYCLES` system clocks before the next one is driven.
- R11: `busy_o` rises on the clock edge that accepts a request and stays high until the last stop step has been held. On the edge where it falls, `done_o` is high for that one cycle. While idle, the pins rest at clock 1, data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to program one register |
| reg_addr_i | input | 3 | Target register address in the synthesizer |
| p_i | input | 8 | Reference divider value P |
| q_i | input | 8 | Feedback divider value Q |
| m_sel_i | input | 3 | Post-divider select M |
| idx_i | input | 4 | Index field |
| prog_clk_o | output | 1 | Program clock wire to the synthesizer |
| prog_dat_o | output | 1 | Program data wire to the synthesizer |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final stop step |

## Verification
The assertions check four things on every cycle. The pins sit at rest whenever the block is idle. `done_o` only ever appears as a lone pulse on the falling edge of `busy_o`. An accepted request always raises `busy_o`. Inside a frame, no pin state changes before it has been held for the full interval. The pin sequences themselves cannot be checked that way: the step order of the preamble, start, zero, one and stop patterns, the field packing and the bit order. Nor can the rule that a request arriving mid-frame is ignored. These are shown only by the bench's scenarios, where a reference model expands each frame into its expected pin states and compares them against the outputs on every clock. The scenarios cover all-zero and all-one field values, a request held across the end of a frame, and stray requests raised during a frame.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_UNLOCK = 3'd1,
    PH_START  = 3'd2,
    PH_BITS   = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  typedef struct packed {
    logic ck;
    logic dt;
  } pins_t;

  localparam int STEP_W      = 4;
  localparam int UNLOCK_LAST = 10;
  localparam int START_LAST  = 3;
  localparam int ZERO_LAST   = 4;
  localparam int ONE_LAST    = 3;
  localparam int STOP_LAST   = 3;

  localparam pins_t PINS_REST = '{ck: 1'b1, dt: 1'b0};

endpackage

// File: rtl/synth_word_pack.sv
`timescale 1ns/1ps
module synth_word_pack #(
  parameter int FIELD_W = 7,
  parameter int SEL_W   = 3,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 3,
  localparam int FRAME_W = 2 * FIELD_W + SEL_W + IDX_W + ADDR_W
) (
  input  logic [FIELD_W:0]   p_i,
  input  logic [FIELD_W:0]   q_i,
  input  logic [SEL_W-1:0]   m_sel_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [FRAME_W-1:0] frame_o
);

  logic [FIELD_W:0] q_off;
  logic [FIELD_W:0] p_off;

  // Offsets the synthesizer expects on the divider values
  assign q_off = q_i - (FIELD_W + 1)'(2);
  assign p_off = p_i - (FIELD_W + 1)'(3);

  // Shifted out from bit 0 upward: word first, address last
  assign frame_o = {addr_i, idx_i, p_off[FIELD_W-1:0], m_sel_i, q_off[FIELD_W-1:0]};

endmodule

// File: rtl/synth_hold_timer.sv
`timescale 1ns/1ps
module synth_hold_timer #(
  parameter int HOLD_CYCLES = 4,
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_n  = CNT_W'(HOLD_CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/synth_step_pattern.sv
`timescale 1ns/1ps
module synth_step_pattern
  import synth_prog_pkg::*;
(
  input  phase_e            phase_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              bit_i,
  output pins_t             pins_o,
  output logic              last_o
);

  always_comb begin
    pins_o = PINS_REST;
    last_o = 1'b0;
    case (phase_i)
      PH_UNLOCK: begin
        // data high; clock low on even steps, high on odd
        pins_o.dt = 1'b1;
        pins_o.ck = step_i[0];
        last_o    = (step_i == STEP_W'(UNLOCK_LAST));
      end
      PH_START: begin
        pins_o.dt = 1'b0;
        pins_o.ck = step_i[0];
        last_o    = (step_i == STEP_W'(START_LAST));
      end
      PH_BITS: begin
        if (bit_i) begin
          case (step_i)
            4'd0:    pins_o = '{ck: 1'b1, dt: 1'b0};
            4'd1:    pins_o = '{ck: 1'b0, dt: 1'b0};
            4'd2:    pins_o = '{ck: 1'b0, dt: 1'b1};
            default: pins_o = '{ck: 1'b1, dt: 1'b1};
          endcase
          last_o = (step_i == STEP_W'(ONE_LAST));
        end else begin
          case (step_i)
            4'd0:    pins_o = '{ck: 1'b1, dt: 1'b0};
            4'd1:    pins_o = '{ck: 1'b1, dt: 1'b1};
            4'd2:    pins_o = '{ck: 1'b0, dt: 1'b1};
            4'd3:    pins_o = '{ck: 1'b0, dt: 1'b0};
            default: pins_o = '{ck: 1'b1, dt: 1'b0};
          endcase
          last_o = (step_i == STEP_W'(ZERO_LAST));
        end
      end
      PH_STOP: begin
        case (step_i)
          4'd0:    pins_o = '{ck: 1'b1, dt: 1'b1};
          4'd1:    pins_o = '{ck: 1'b0, dt: 1'b1};
          4'd2:    pins_o = '{ck: 1'b1, dt: 1'b1};
          default: pins_o = '{ck: 1'b1, dt: 1'b0};
        endcase
        last_o = (step_i == STEP_W'(STOP_LAST));
      end
      default: begin
        pins_o = PINS_REST;
        last_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/synth_reg_loader.sv
`timescale 1ns/1ps
module synth_reg_loader
  import synth_prog_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int FIELD_W     = 7,
  parameter int SEL_W       = 3,
  parameter int IDX_W       = 4,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [FIELD_W:0]  p_i,
  input  logic [FIELD_W:0]  q_i,
  input  logic [SEL_W-1:0]  m_sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              prog_clk_o,
  output logic              prog_dat_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int FRAME_W = 2 * FIELD_W + SEL_W + IDX_W + ADDR_W;
  localparam int BIT_W   = $clog2(FRAME_W);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Word packing
  logic [FRAME_W-1:0] frame_in;
  logic [FRAME_W-1:0] frame_q;

  synth_word_pack #(
    .FIELD_W(FIELD_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_pack (
    .p_i(p_i), .q_i(q_i), .m_sel_i(m_sel_i), .idx_i(idx_i),
    .addr_i(reg_addr_i), .frame_o(frame_in)
  );

  // Sequencer state
  phase_e            phase_q, phase_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [BIT_W-1:0]  bidx_q, bidx_n;
  pins_t             pins_q, pins_n;
  logic              done_q, done_n;
  logic              accept, advance, hold_load, hold_expired;
  logic              cur_last;
  pins_t             cur_pins_unused;

  assign accept  = (phase_q == PH_IDLE) && start_i;
  assign advance = (phase_q != PH_IDLE) && hold_expired;

  synth_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .load_i(hold_load), .expired_o(hold_expired)
  );

  // Pattern for the step being held: only its last-step flag is used
  synth_step_pattern u_cur (
    .phase_i(phase_q), .step_i(step_q), .bit_i(frame_q[bidx_q]),
    .pins_o(cur_pins_unused), .last_o(cur_last)
  );

  always_comb begin
    phase_n = phase_q;
    step_n  = step_q;
    bidx_n  = bidx_q;
    done_n  = 1'b0;
    if (accept) begin
      phase_n = PH_UNLOCK;
      step_n  = '0;
      bidx_n  = '0;
    end else if (advance) begin
      if (!cur_last) begin
        step_n = step_q + 1'b1;
      end else begin
        step_n = '0;
        case (phase_q)
          PH_UNLOCK: phase_n = PH_START;
          PH_START: begin
            phase_n = PH_BITS;
            bidx_n  = '0;
          end
          PH_BITS: begin
            if (bidx_q == BIT_W'(FRAME_W - 1)) begin
              phase_n = PH_STOP;
            end else begin
              bidx_n = bidx_q + 1'b1;
            end
          end
          default: begin
            phase_n = PH_IDLE;
            done_n  = 1'b1;
          end
        endcase
      end
    end
  end

  assign hold_load = accept || (advance && (phase_n != PH_IDLE));

  // Pattern for the step about to be driven
  logic nxt_last_unused;
  synth_step_pattern u_nxt (
    .phase_i(phase_n), .step_i(step_n), .bit_i(frame_q[bidx_n]),
    .pins_o(pins_n), .last_o(nxt_last_unused)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      bidx_q  <= '0;
      pins_q  <= PINS_REST;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      if (accept || advance) begin
        phase_q <= phase_n;
        step_q  <= step_n;
        bidx_q  <= bidx_n;
        pins_q  <= pins_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      frame_q <= '0;
    end else if (accept) begin
      frame_q <= frame_in;
    end
  end

  assign prog_clk_o = pins_q.ck;
  assign prog_dat_o = pins_q.dt;
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/synth_prog_chk.sv
`timescale 1ns/1ps
module synth_prog_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic prog_clk_o,
  input logic prog_dat_o,
  input logic busy_o,
  input logic done_o
);

  logic [1:0]  prev_pins;
  logic [15:0] run_len;
  logic        busy_d;
  logic [1:0]  cur_pins;

  assign cur_pins = {prog_clk_o, prog_dat_o};

  // Cycles the previous pin state has lasted, minus one, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pins <= 2'b10;
      run_len   <= '0;
      busy_d    <= 1'b0;
    end else begin
      prev_pins <= cur_pins;
      busy_d    <= busy_o;
      if (cur_pins != prev_pins) begin
        run_len <= '0;
      end else if (int'(run_len) < HOLD_CYCLES) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  assert_idle_rest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_clk_o && !prog_dat_o));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_on_busy_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_step_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_pins != prev_pins) && busy_d) |-> (int'(run_len) >= HOLD_CYCLES - 1));

endmodule

bind synth_reg_loader synth_prog_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .start_i(start_i),
  .prog_clk_o(prog_clk_o),
  .prog_dat_o(prog_dat_o),
  .busy_o(busy_o),
  .done_o(done_o)
);

// File: tb/sim_synth_reg_loader.sv
`timescale 1ns/1ps
module sim_synth_reg_loader;

  localparam int HOLD = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [2:0] reg_addr_i;
  logic [7:0] p_i, q_i;
  logic [2:0] m_sel_i;
  logic [3:0] idx_i;
  logic       prog_clk_o, prog_dat_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  synth_reg_loader #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_addr_i(reg_addr_i),
    .p_i(p_i), .q_i(q_i), .m_sel_i(m_sel_i), .idx_i(idx_i),
    .prog_clk_o(prog_clk_o), .prog_dat_o(prog_dat_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // Reference model: one queue entry per expected cycle
  logic [1:0] pinq[$];
  string      tagq[$];
  logic [1:0] exp_pins;
  logic       exp_busy, exp_done;
  string      cur_tag;
  int         frames_exp = 0;
  int         done_seen  = 0;

  task automatic push_step(input logic c, input logic d, input string tag);
    for (int k = 0; k < HOLD; k++) begin
      pinq.push_back({c, d});
      tagq.push_back(tag);
    end
  endtask

  task automatic build_frame();
    logic [20:0] w;
    logic        b;
    // R9 packing: Q-2 at 6..0, M at 9..7, P-3 at 16..10, index at 20..17
    w = {idx_i, 7'(p_i - 8'd3), m_sel_i, 7'(q_i - 8'd2)};
    push_step(1'b0, 1'b1, "R3");
    for (int k = 0; k < 5; k++) begin
      push_step(1'b1, 1'b1, "R3");
      push_step(1'b0, 1'b1, "R3");
    end
    push_step(1'b0, 1'b0, "R4");
    push_step(1'b1, 1'b0, "R4");
    push_step(1'b0, 1'b0, "R4");
    push_step(1'b1, 1'b0, "R4");
    for (int k = 0; k < 24; k++) begin
      b = (k < 21) ? w[k] : reg_addr_i[k-21];   // R8 order
      if (b) begin
        push_step(1'b1, 1'b0, "R6/R8/R9");
        push_step(1'b0, 1'b0, "R6/R8/R9");
        push_step(1'b0, 1'b1, "R6/R8/R9");
        push_step(1'b1, 1'b1, "R6/R8/R9");
      end else begin
        push_step(1'b1, 1'b0, "R5/R8/R9");
        push_step(1'b1, 1'b1, "R5/R8/R9");
        push_step(1'b0, 1'b1, "R5/R8/R9");
        push_step(1'b0, 1'b0, "R5/R8/R9");
        push_step(1'b1, 1'b0, "R5/R8/R9");
      end
    end
    push_step(1'b1, 1'b1, "R7");
    push_step(1'b0, 1'b1, "R7");
    push_step(1'b1, 1'b1, "R7");
    push_step(1'b1, 1'b0, "R7");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pinq.delete();
      tagq.delete();
      exp_pins = 2'b10;
      exp_busy = 1'b0;
      exp_done = 1'b0;
      cur_tag  = "R1";
    end else begin
      exp_done = 1'b0;
      if (!exp_busy && start_i) begin
        build_frame();
        frames_exp++;
      end
      if (pinq.size() > 0) begin
        exp_pins = pinq.pop_front();
        cur_tag  = tagq.pop_front();
        exp_busy = 1'b1;
      end else if (exp_busy) begin
        exp_busy = 1'b0;
        exp_done = 1'b1;
        cur_tag  = "R11";
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      checks++;
      if (done_o) done_seen++;
      if ({prog_clk_o, prog_dat_o} !== exp_pins || busy_o !== exp_busy || done_o !== exp_done) begin
        fails++;
        $display("FAIL %s/R10/R11 t=%0t pins=%b busy=%b done=%b expected pins=%b busy=%b done=%b",
                 cur_tag, $time, {prog_clk_o, prog_dat_o}, busy_o, done_o,
                 exp_pins, exp_busy, exp_done);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: busy=%b expected 0", busy_o);
    finish_run();
  end

  task automatic set_fields(input logic [2:0] a, input logic [7:0] p, input logic [7:0] q,
                            input logic [2:0] m, input logic [3:0] x);
    reg_addr_i = a; p_i = p; q_i = q; m_sel_i = m; idx_i = x;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || exp_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic one_frame(input logic [2:0] a, input logic [7:0] p, input logic [7:0] q,
                           input logic [2:0] m, input logic [3:0] x);
    @(negedge clk);
    set_fields(a, p, q, m, x);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    set_fields(~a, ~p, ~q, ~m, ~x);   // captured at acceptance; changes must not matter
    wait_idle();
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    set_fields(3'd0, 8'd3, 8'd2, 3'd0, 4'd0);
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({prog_clk_o, prog_dat_o, busy_o, done_o} !== 4'b1000) begin
      fails++;
      $display("FAIL R1 reset: pins/busy/done=%b expected 1000",
               {prog_clk_o, prog_dat_o, busy_o, done_o});
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Mixed field values
    one_frame(3'd5, 8'd100, 8'd40, 3'd2, 4'd9);
    // All-zero word and address (every bit sent as a zero, R5)
    one_frame(3'd0, 8'd3, 8'd2, 3'd0, 4'd0);
    // All-one word and address (every bit sent as a one, R6)
    one_frame(3'd7, 8'd130, 8'd129, 3'd7, 4'd15);

    // R2: stray requests during a running frame are ignored
    @(negedge clk);
    set_fields(3'd3, 8'd61, 8'd77, 3'd4, 4'd6);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    // R11: request held across the end of a frame starts the next one at once
    @(negedge clk);
    set_fields(3'd1, 8'd50, 8'd21, 3'd1, 4'd3);
    start_i = 1'b1;
    while (frames_exp < 6) @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    // R2: one done pulse per accepted request
    checks++;
    if (done_seen != frames_exp || frames_exp != 6) begin
      fails++;
      $display("FAIL R2 done pulses=%0d frames=%0d expected 6 and 6", done_seen, frames_exp);
    end
    // R11: pins at rest between frames
    checks++;
    if ({prog_clk_o, prog_dat_o, busy_o} !== 3'b100) begin
      fails++;
      $display("FAIL R11 idle pins/busy=%b expected 100", {prog_clk_o, prog_dat_o, busy_o});
    end
    finish_run();
  end

endmodule